// File: doc/BRIEF.md
# Fast link pulse burst generator

The block sends a 16-bit link code word as one burst of logic-level link pulses on a single output. A burst has 33 slots. Every even slot, counted from zero, holds a framing pulse that is always present. Each odd slot holds one data bit: a pulse means 1 and no pulse means 0. The slot length and the pulse width are parameters in clock cycles. With the default values at 125 MHz, framing pulses are about 62.5 us apart.

Software or a neighbouring controller stages a word with a load strobe and starts sending with a start strobe. While enable stays high, the block repeats the burst at a fixed interval, measured from one burst start to the next. The default interval is about 16 ms. A word loaded while a burst is running waits for the next burst boundary. Dropping enable stops everything in the same cycle. After reset the staged word is 16'h0001, so the 5-bit selector field in bits 4:0 declares standard Ethernet compliance.

Top module: `flp_burst_gen`

## Requirements
- R1: After reset, pulse_out, busy and done are low. The staged word is 16'h0001.
- R2: A start strobe sampled while enable is high and no burst is running begins a burst at that edge. From the next cycle, busy is high and pulse_out is high for the first slot.
- R3: A burst lasts exactly 33 slots of SLOT_CLKS cycles each. In every even slot (0, 2, ... 32), pulse_out is high for the first PULSE_CLKS cycles of the slot and low for the rest.
- R4: Odd slot 2k+1 carries bit k of the active word, starting with bit 0. pulse_out is high for the first PULSE_CLKS cycles of that slot only if the bit is 1.
- R5: When the last slot ends, busy falls and done is high for exactly one cycle.
- R6: While enable stays high, a new burst starts INTERVAL_CLKS cycles after the previous burst start. When that instant coincides with the end of a burst, the next burst follows with no idle cycle, and done still pulses.
- R7: word_load stores word_in. The stored word is copied to the active word only when a burst starts. A load in the same cycle as a burst start is used by that burst.
- R8: While enable is low, pulse_out and busy are low in the same cycle and done stays low. Slot, position and interval state clear. Raising enable again starts nothing until a start strobe arrives.
- R9: A start strobe during a burst is ignored. The burst keeps its timing and its word.
- R10: A start strobe in the gap between bursts begins a burst at once and restarts the interval count from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Keeps the generator running; low stops it at once |
| start | input | 1 | Single-cycle request to begin a burst |
| word_load | input | 1 | Stores word_in as the staged word |
| word_in | input | 16 | Link code word to stage |
| pulse_out | output | 1 | Logic-level link pulse strobe |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle flag after the final framing slot |

## Verification
Two groups of events can fall on the same clock edge. A word load can land on the same edge as a burst start. The end of a burst can land on the same edge as the expiry of the repeat interval. The bench waits for done on one instance, then raises start and word_load together in the following gap. It also runs a second instance whose interval equals exactly 33 slots, so every burst end meets a repeat. A behavioural model predicts pulse_out, busy and done on every cycle, and the bench compares the design against it: the new word must appear in the data slots of that very burst, and done must pulse even though busy never falls.

// File: rtl/flp_pkg.sv
package flp_pkg;
    localparam int WORD_W    = 16;
    localparam int SLOTS     = 2 * WORD_W + 1;
    localparam int POS_W     = $clog2(SLOTS);
    localparam int LAST_SLOT = SLOTS - 1;
    localparam logic [WORD_W-1:0] RESET_WORD = 16'h0001;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_GAP   = 2'd2
    } flp_state_e;
endpackage

// File: rtl/flp_slot_timer.sv
module flp_slot_timer #(
    parameter int SLOT_CLKS  = 3906,
    parameter int PULSE_CLKS = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic slot_end,
    output logic in_window
);
    localparam int CW = $clog2(SLOT_CLKS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign slot_end  = run && (cnt_q == CW'(SLOT_CLKS - 1));
    assign in_window = (cnt_q < CW'(PULSE_CLKS));

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = slot_end ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/flp_interval_timer.sv
module flp_interval_timer #(
    parameter int INTERVAL_CLKS = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count,
    input  logic clear,
    output logic due
);
    localparam int IW = $clog2(INTERVAL_CLKS + 1);

    logic [IW-1:0] cnt_d, cnt_q;

    assign due = count && (cnt_q == IW'(INTERVAL_CLKS - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (count && !due) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/flp_slot_mux.sv
module flp_slot_mux
    import flp_pkg::*;
(
    input  logic [4:0]        slot_idx,
    input  logic [WORD_W-1:0] word,
    output logic              level
);
    always_comb begin
        if (slot_idx[0]) level = word[slot_idx[4:1]];
        else             level = 1'b1;
    end
endmodule

// File: rtl/flp_burst_gen.sv
module flp_burst_gen
    import flp_pkg::*;
#(
    parameter int SLOT_CLKS     = 3906,
    parameter int PULSE_CLKS    = 13,
    parameter int INTERVAL_CLKS = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic              word_load,
    input  logic [WORD_W-1:0] word_in,
    output logic              pulse_out,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        flp_state_e        state;
        logic [POS_W-1:0]  pos;
        logic [WORD_W-1:0] word_act;
        logic [WORD_W-1:0] word_pend;
        logic              done;
    } flp_regs_t;

    flp_regs_t r_d, r_q;

    logic slot_end, in_window, due, level;
    logic end_now, go, in_burst;

    assign in_burst = (r_q.state == ST_BURST);
    assign end_now  = in_burst && slot_end && (r_q.pos == POS_W'(LAST_SLOT));
    assign go       = enable &&
                      ((start && !in_burst) ||
                       (due && ((r_q.state == ST_GAP) || end_now)));

    flp_slot_timer #(
        .SLOT_CLKS (SLOT_CLKS),
        .PULSE_CLKS(PULSE_CLKS)
    ) i_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable && in_burst),
        .clear    (go || !enable),
        .slot_end (slot_end),
        .in_window(in_window)
    );

    flp_interval_timer #(
        .INTERVAL_CLKS(INTERVAL_CLKS)
    ) i_interval (
        .clk  (clk),
        .rst_n(rst_n),
        .count(enable && (r_q.state != ST_IDLE)),
        .clear(go || !enable),
        .due  (due)
    );

    flp_slot_mux i_mux (
        .slot_idx(r_q.pos[4:0]),
        .word    (r_q.word_act),
        .level   (level)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = enable && end_now;
        if (word_load) begin
            r_d.word_pend = word_in;
        end
        if (!enable) begin
            r_d.state = ST_IDLE;
            r_d.pos   = '0;
        end else if (go) begin
            r_d.state    = ST_BURST;
            r_d.pos      = '0;
            r_d.word_act = word_load ? word_in : r_q.word_pend;
        end else if (in_burst && slot_end) begin
            if (end_now) r_d.state = ST_GAP;
            else         r_d.pos   = r_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.pos       <= '0;
            r_q.word_act  <= RESET_WORD;
            r_q.word_pend <= RESET_WORD;
            r_q.done      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = enable && in_burst;
    assign pulse_out = busy && in_window && level;
    assign done      = r_q.done;
endmodule

// File: rtl/flp_burst_chk.sv
module flp_burst_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic        start,
    input logic        word_load,
    input logic [15:0] word_in,
    input logic        pulse_out,
    input logic        busy,
    input logic        done
);
    // R8
    off_is_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!pulse_out && !busy));

    // R3
    pulse_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> busy);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R2
    start_begins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && enable && !busy) |=> (busy || !enable));

    // R2
    first_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && enable && !busy) |=> (pulse_out || !enable));

    wire unused_ok = &{1'b0, word_load, word_in};
endmodule

bind flp_burst_gen flp_burst_chk i_chk (.*);

// File: tb/test_flp_burst_gen.sv
module flp_ref_model #(
    parameter int S = 4,
    parameter int P = 2,
    parameter int I = 140
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        start,
    input  logic        word_load,
    input  logic [15:0] word_in,
    output logic        exp_pulse,
    output logic        exp_busy,
    output logic        exp_done
);
    int st, pos, cnt, rep;
    logic [15:0] act, pend;
    logic dn;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st = 0; pos = 0; cnt = 0; rep = 0;
            act = 16'h0001; pend = 16'h0001; dn = 0;
        end else begin
            int o_st;
            bit end_now, due, go;
            o_st    = st;
            end_now = (o_st == 1) && (cnt == S - 1) && (pos == 32);
            due     = (o_st != 0) && (rep == I - 1);
            go      = enable && ((start && o_st != 1) || (due && (o_st == 2 || end_now)));
            dn      = enable && end_now;
            if (!enable) begin
                st = 0; pos = 0; cnt = 0; rep = 0;
            end else if (go) begin
                st = 1; pos = 0; cnt = 0; rep = 0;
                act = word_load ? word_in : pend;
            end else begin
                if (o_st != 0) rep = rep + 1;
                if (o_st == 1) begin
                    if (cnt == S - 1) begin
                        cnt = 0;
                        if (pos == 32) st = 2;
                        else pos = pos + 1;
                    end else begin
                        cnt = cnt + 1;
                    end
                end
            end
            if (word_load) pend = word_in;
        end
    end

    always @* begin
        exp_busy  = enable && (st == 1);
        exp_pulse = exp_busy && (cnt < P) && ((pos % 2 == 0) || act[pos / 2]);
        exp_done  = dn;
    end
endmodule

module test_flp_burst_gen;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        enable = 0;
    logic        start = 0;
    logic        word_load = 0;
    logic [15:0] word_in = 16'h0;

    logic a_pulse, a_busy, a_done, b_pulse, b_busy, b_done;
    logic ea_pulse, ea_busy, ea_done, eb_pulse, eb_busy, eb_done;

    int    checks = 0;
    int    bad = 0;
    bit    chk_on = 0;
    bit    finished = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    flp_burst_gen #(.SLOT_CLKS(4), .PULSE_CLKS(2), .INTERVAL_CLKS(140)) i_flp_burst_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .word_load(word_load), .word_in(word_in),
        .pulse_out(a_pulse), .busy(a_busy), .done(a_done));

    flp_burst_gen #(.SLOT_CLKS(4), .PULSE_CLKS(2), .INTERVAL_CLKS(132)) i_flp_burst_gen_b (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .word_load(word_load), .word_in(word_in),
        .pulse_out(b_pulse), .busy(b_busy), .done(b_done));

    flp_ref_model #(.S(4), .P(2), .I(140)) i_ref_a (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .word_load(word_load), .word_in(word_in),
        .exp_pulse(ea_pulse), .exp_busy(ea_busy), .exp_done(ea_done));

    flp_ref_model #(.S(4), .P(2), .I(132)) i_ref_b (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .word_load(word_load), .word_in(word_in),
        .exp_pulse(eb_pulse), .exp_busy(eb_busy), .exp_done(eb_done));

    task automatic cmp(input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s at %0t: got=%b expected=%b", cur_req, what, $time, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !finished) begin
            cmp("a.pulse_out", a_pulse, ea_pulse);
            cmp("a.busy",      a_busy,  ea_busy);
            cmp("a.done",      a_done,  ea_done);
            cmp("b.pulse_out", b_pulse, eb_pulse);
            cmp("b.busy",      b_busy,  eb_busy);
            cmp("b.done",      b_done,  eb_done);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic pulse_start(input bit with_load, input logic [15:0] w);
        start     = 1;
        word_load = with_load;
        word_in   = w;
        tick(1);
        start     = 0;
        word_load = 0;
    endtask

    task automatic load_word(input logic [15:0] w);
        word_load = 1;
        word_in   = w;
        tick(1);
        word_load = 0;
    endtask

    initial begin
        chk_on = 1;
        cur_req = "R1";
        tick(4);
        rst_n = 1;
        tick(4);
        checks++;
        if (a_pulse !== 1'b0 || a_busy !== 1'b0 || a_done !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset outputs: got=%b%b%b expected=000", a_pulse, a_busy, a_done);
        end

        // R2 / R3 / R4: first burst with the reset word, then a loaded word
        enable = 1;
        cur_req = "R2";
        pulse_start(0, 16'h0);
        cur_req = "R3";
        tick(60);
        // R7: load during a burst must wait for the next boundary
        cur_req = "R7";
        load_word(16'hA5C3);
        // R9: start during a burst is ignored
        cur_req = "R9";
        pulse_start(0, 16'h0);
        cur_req = "R5";
        tick(80);
        // R6: repeats at the interval (B back to back, A after a gap)
        cur_req = "R6";
        tick(300);
        cur_req = "R4";
        load_word(16'h3C5A);
        tick(200);

        // R10 / R7: start together with load in A's gap
        cur_req = "R10";
        while (!a_done) @(negedge clk);
        tick(1);
        pulse_start(1, 16'hFFFF);
        tick(160);
        cur_req = "R7";
        while (!a_done) @(negedge clk);
        tick(2);
        pulse_start(1, 16'h0000);
        tick(150);

        // R8: drop enable mid burst, then re-enable with no start
        cur_req = "R8";
        tick(37);
        enable = 0;
        tick(12);
        enable = 1;
        tick(200);
        checks++;
        if (a_busy !== 1'b0) begin
            bad++;
            $display("FAIL R8 restart without start: got busy=%b expected=0", a_busy);
        end
        cur_req = "R2";
        pulse_start(1, 16'h8001);
        tick(400);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule